// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Generator

The block emits one high pulse on `pulse_out` for each rising edge of a selected trigger. The trigger is either a software-driven level bit or an external pin, and a mode input chooses between them. An accepted edge loads the active width register from a software-written shadow register and starts a run counter at one. The output stays high while the counter climbs. When the count equals the active width, the output drops and the counter holds until the next accepted edge.

An event counter counts accepted triggers. Every third one sets a sticky interrupt flag, which software clears with a strobe. The intended use is for the interrupt handler to write a new width into the shadow register after each group of three triggers. The new width takes effect on the next pulse and never on a pulse already in progress.

The control state machine has two states. `ST_IDLE` means no pulse is running. `ST_RUN` means a pulse is being timed. The transition `ST_IDLE -> ST_RUN` ("launch") happens on an accepted edge. The transition `ST_RUN -> ST_IDLE` ("expire") happens when the run count equals the active width. Every other case holds the current state.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A pulse starts only on a 0-to-1 transition of the selected trigger. A trigger held high starts no further pulse until it has gone low and risen again.
- R2: In software mode, `pulse_out` goes high at the first clock edge after `sw_trig` rises. It then stays high for exactly the active width in clock cycles, and afterwards stays low until the next accepted edge.
- R3: Every third accepted trigger sets `irq`. The first and second accepted triggers of each group leave `irq` unchanged.
- R4: `irq` is sticky and stays set until `irq_clr` is pulsed. A clear leaves `irq` low.
- R5: A `shadow_wr` write goes into the shadow register only. The shadow value is copied into the active width when a pulse starts, so a write made during a pulse does not change that pulse's width but does set the width of the next pulse.
- R6: A trigger edge that arrives while a pulse is running is ignored. It neither extends the pulse nor counts toward the interrupt.
- R7: With `mode_ext` = 0 the trigger is `sw_trig` and `ext_trig` has no effect. With `mode_ext` = 1 the trigger is `ext_trig` and `sw_trig` has no effect.
- R8: `ext_trig` passes through a two-stage synchronizer, so `pulse_out` rises at the third clock edge after `ext_trig` rises. A periodic trigger with a period of 125 cycles and 12 cycles high yields exactly one pulse per period.
- R9: When the shadow width is zero, a trigger edge produces no pulse and is not counted.
- R10: After reset, `pulse_out` and `irq` are low and the shadow width is 20 cycles.
- R11: Widths from 20 to 80 cycles in steps of 5 are each reproduced exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | Trigger source: 0 software bit, 1 external pin |
| sw_trig | input | 1 | Software trigger level |
| ext_trig | input | 1 | External trigger pin (asynchronous) |
| shadow_wr | input | 1 | Write strobe for the shadow width |
| shadow_din | input | CNT_W (8) | Width value in clock cycles |
| irq_clr | input | 1 | Clears the sticky interrupt |
| pulse_out | output | 1 | One-shot pulse |
| irq | output | 1 | Sticky flag, set on every third accepted trigger |

## Verification
The assertions assume that `mode_ext` does not change while a trigger level is high. Switching sources would compare values from two different signals and could make the edge detector see a false edge. The bench changes the mode only with both triggers low and the block idle. The assertions also assume that `sw_trig` is low when reset is released. The bench drives every input low during reset and changes inputs only on falling clock edges.

// File: rtl/osp_pkg.sv
package osp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } osp_state_e;
endpackage

// File: rtl/osp_trig_front.sv
module osp_trig_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ext,
    input  logic sw_trig,
    input  logic ext_trig,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_s;
    logic                   sel;
    logic                   sel_d;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_trig;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign ext_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        sel = mode_ext ? ext_s : sw_trig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_d <= 1'b0;
        else        sel_d <= sel;
    end

    assign rise = sel & ~sel_d;
endmodule

// File: rtl/osp_width_regs.sv
module osp_width_regs #(
    parameter int CNT_W     = 8,
    parameter int RST_WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shadow_wr,
    input  logic [CNT_W-1:0] shadow_din,
    input  logic             load,
    output logic             shadow_zero,
    output logic [CNT_W-1:0] act_width
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_WIDTH);

    logic [CNT_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_q <= RST_VAL;
        else if (shadow_wr) shadow_q <= shadow_din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    act_width <= RST_VAL;
        else if (load) act_width <= shadow_q;
    end

    assign shadow_zero = (shadow_q == '0);
endmodule

// File: rtl/osp_evt_ctr.sv
module osp_evt_ctr #(
    parameter int PERIOD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic irq_clr,
    output logic irq
);
    localparam int                CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0]     LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit = accept && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (hit)    cnt <= '0;
        else if (accept) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (hit)     irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen #(
    parameter int CNT_W       = 8,
    parameter int RST_WIDTH   = 20,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_PERIOD  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ext,
    input  logic             sw_trig,
    input  logic             ext_trig,
    input  logic             shadow_wr,
    input  logic [CNT_W-1:0] shadow_din,
    input  logic             irq_clr,
    output logic             pulse_out,
    output logic             irq
);
    import osp_pkg::*;

    osp_state_e       state, state_nx;
    logic             rise;
    logic             accept;
    logic             shadow_zero;
    logic [CNT_W-1:0] act_width;
    logic [CNT_W-1:0] run_cnt;
    logic             at_match;

    osp_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext),
        .sw_trig(sw_trig), .ext_trig(ext_trig), .rise(rise)
    );

    osp_width_regs #(.CNT_W(CNT_W), .RST_WIDTH(RST_WIDTH)) u_width (
        .clk(clk), .rst_n(rst_n), .shadow_wr(shadow_wr),
        .shadow_din(shadow_din), .load(accept),
        .shadow_zero(shadow_zero), .act_width(act_width)
    );

    osp_evt_ctr #(.PERIOD(IRQ_PERIOD)) u_evt (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .irq_clr(irq_clr), .irq(irq)
    );

    assign accept   = (state == ST_IDLE) && rise && !shadow_zero;
    assign at_match = (run_cnt == act_width);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: launch and expire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nx = ST_RUN;
            ST_RUN:  if (at_match) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // run counter, restarts at one on launch
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_cnt <= '0;
        else if (accept)                     run_cnt <= CNT_W'(1);
        else if (state == ST_RUN && !at_match) run_cnt <= run_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        pulse_out = 1'b0;
        unique case (state)
            ST_IDLE: pulse_out = 1'b0;
            ST_RUN:  pulse_out = 1'b1;
            default: pulse_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/oneshot_pulse_gen_chk.sv
module oneshot_pulse_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pulse_out,
    input logic             irq,
    input logic             irq_clr,
    input logic             rise,
    input logic             accept,
    input logic [CNT_W-1:0] act_width,
    input logic [CNT_W-1:0] run_cnt
);
    // R1: a pulse begins only after a detected edge
    a_r1_start_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(rise));

    // R2: counter never passes the active width while high
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (run_cnt <= act_width) && (run_cnt != '0));

    // R3: interrupt only appears after an accepted trigger
    a_r3_irq_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(accept));

    // R4: sticky until cleared
    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R5: active width frozen during a running pulse
    a_r5_width_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && $past(pulse_out)) |-> $stable(act_width));

    // R6: no acceptance while running
    a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> !accept);

    // R9: a launched pulse never has zero width
    a_r9_nonzero_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> (act_width != '0));
endmodule

bind oneshot_pulse_gen oneshot_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .irq(irq),
    .irq_clr(irq_clr), .rise(rise), .accept(accept),
    .act_width(act_width), .run_cnt(run_cnt)
);

// File: tb/test_oneshot_pulse_gen.sv
module test_oneshot_pulse_gen;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_ext, sw_trig, ext_trig, shadow_wr, irq_clr;
    logic [CNT_W-1:0] shadow_din;
    logic             pulse_out, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    oneshot_pulse_gen #(.CNT_W(CNT_W)) i_oneshot_pulse_gen (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .sw_trig(sw_trig),
        .ext_trig(ext_trig), .shadow_wr(shadow_wr), .shadow_din(shadow_din),
        .irq_clr(irq_clr), .pulse_out(pulse_out), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_ext = 1'b0; sw_trig = 1'b0; ext_trig = 1'b0;
        shadow_wr = 1'b0; shadow_din = '0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_width(input int v);
        @(negedge clk);
        shadow_wr = 1'b1; shadow_din = CNT_W'(v);
        @(negedge clk);
        shadow_wr = 1'b0;
    endtask

    // waits for a pulse after a trigger was driven; lat=-1 if none
    task automatic measure(input int limit, output int lat, output int w);
        lat = 0; w = 0;
        while (lat < limit) begin
            @(negedge clk);
            lat++;
            if (pulse_out) break;
        end
        if (!pulse_out) begin
            lat = -1;
            return;
        end
        w = 1;
        forever begin
            @(negedge clk);
            if (pulse_out) w++;
            else break;
        end
    endtask

    task automatic sw_fire(output int lat, output int w);
        @(negedge clk); sw_trig = 1'b0;
        @(negedge clk); sw_trig = 1'b1;
        measure(150, lat, w);
    endtask

    task automatic t_reset();
        int lat, w;
        do_reset();
        check("R10 pulse_out after reset", pulse_out, 0);
        check("R10 irq after reset", irq, 0);
        sw_fire(lat, w);
        check("R10 default width", w, 20);
    endtask

    task automatic t_basic_sw();
        int lat, w;
        do_reset();
        sw_fire(lat, w);
        check("R2 sw start latency", lat, 1);
        check("R2 width", w, 20);
        // trigger still high: no second pulse
        measure(60, lat, w);
        check("R1 held level no retrigger", lat, -1);
        sw_fire(lat, w);
        check("R1 re-armed after low", w, 20);
    endtask

    task automatic t_irq();
        int lat, w;
        do_reset();
        sw_fire(lat, w);
        sw_fire(lat, w);
        check("R3 irq low after two", irq, 0);
        sw_fire(lat, w);
        check("R3 irq high after third", irq, 1);
        sw_trig = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 irq sticky", irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
        check("R4 irq cleared", irq, 0);
        sw_fire(lat, w); sw_fire(lat, w);
        check("R3 second group not yet", irq, 0);
        sw_fire(lat, w);
        check("R3 second group third", irq, 1);
    endtask

    task automatic t_shadow();
        int lat, w, hi;
        do_reset();
        write_width(35);
        sw_fire(lat, w);
        check("R5 new width used", w, 35);
        write_width(20);
        @(negedge clk); sw_trig = 1'b0;
        @(negedge clk); sw_trig = 1'b1;
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 5) begin shadow_wr = 1'b1; shadow_din = CNT_W'(50); end
            else shadow_wr = 1'b0;
            if (pulse_out) hi++;
        end
        check("R5 mid-pulse write no effect", hi, 20);
        sw_fire(lat, w);
        check("R5 write applies next pulse", w, 50);
    endtask

    task automatic t_busy_ignore();
        int hi, starts, lat, w;
        bit prev;
        do_reset();
        @(negedge clk); sw_trig = 1'b1;
        hi = 0; starts = 0; prev = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 4) sw_trig = 1'b0;
            if (i == 7) sw_trig = 1'b1;
            if (pulse_out) hi++;
            if (pulse_out && !prev) starts++;
            prev = pulse_out;
        end
        check("R6 width unchanged by busy edge", hi, 20);
        check("R6 single pulse", starts, 1);
        sw_fire(lat, w);
        check("R6 busy edge not counted", irq, 0);
        sw_fire(lat, w);
        check("R6 third accepted sets irq", irq, 1);
    endtask

    task automatic t_zero();
        int lat, w;
        do_reset();
        write_width(0);
        sw_fire(lat, w);
        check("R9 zero width no pulse", lat, -1);
        sw_fire(lat, w); sw_fire(lat, w);
        check("R9 zero width not counted", irq, 0);
        write_width(25);
        sw_fire(lat, w);
        check("R9 recovers", w, 25);
    endtask

    task automatic t_ext();
        int lat, w, hi, starts;
        bit prev;
        do_reset();
        write_width(80);
        @(negedge clk); mode_ext = 1'b1;
        repeat (4) @(negedge clk);
        @(negedge clk); ext_trig = 1'b1;
        measure(20, lat, w);
        check("R8 ext latency", lat, 3);
        check("R8 ext width", w, 80);
        ext_trig = 1'b0;
        // software bit must not fire in ext mode
        @(negedge clk); sw_trig = 1'b1;
        measure(30, lat, w);
        check("R7 sw ignored in ext mode", lat, -1);
        sw_trig = 1'b0;
        hi = 0; starts = 0; prev = 1'b0;
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 125; c++) begin
                @(negedge clk);
                ext_trig = (c < 12);
                if (pulse_out) hi++;
                if (pulse_out && !prev) starts++;
                prev = pulse_out;
            end
        end
        repeat (90) begin
            @(negedge clk);
            ext_trig = 1'b0;
            if (pulse_out) hi++;
            if (pulse_out && !prev) starts++;
            prev = pulse_out;
        end
        check("R8 one pulse per period", starts, 5);
        check("R8 total high cycles", hi, 400);
        // back to sw mode: ext ignored
        @(negedge clk); mode_ext = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig = 1'b1;
        measure(30, lat, w);
        check("R7 ext ignored in sw mode", lat, -1);
        ext_trig = 1'b0;
    endtask

    task automatic t_range();
        int lat, w;
        do_reset();
        for (int v = 20; v <= 80; v += 5) begin
            write_width(v);
            sw_fire(lat, w);
            check($sformatf("R11 width %0d", v), w, v);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        mode_ext = 1'b0; sw_trig = 1'b0; ext_trig = 1'b0;
        shadow_wr = 1'b0; shadow_din = '0; irq_clr = 1'b0;
        t_reset();
        t_basic_sw();
        t_irq();
        t_shadow();
        t_busy_ignore();
        t_zero();
        t_ext();
        t_range();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule